// File: doc/BRIEF.md
# Delayed Read Completion Tracker

This block tracks a single deferred read for the target side of a bus bridge. When a read arrives that cannot be answered straight away, the tracker records its address and command, tells the requester to retry, and issues a one-cycle fetch pulse so that the downstream side starts the access. While the downstream access is in flight, every request is retried, including one that matches.

Once the downstream side reports that the completion is ready, the tracker waits for the original requester to come back. A re-request whose address and command both match the recorded ones is answered with a hit, and the slot empties. A request that does not match is retried. A completion that nobody claims is not held for ever. A timer starts on completion-ready and counts `EXPIRE_CYCLES` clocks, which is 65536 by default. When it runs out, the tracker raises a one-cycle discard pulse and frees the slot. No hit and no other indication goes with the discard. A different request can then take the slot. Data storage belongs to the surrounding logic.

Top module: `rd_defer_tracker`

## Requirements
- R1: After reset, req_hit, req_retry, discard and fetch_go are all 0 while no request is presented, and the slot is empty, so the first request presented is recorded.
- R2: A request presented while the slot is empty is answered with req_retry in the same cycle and recorded. In the next cycle fetch_go is 1 for one cycle, and fetch_addr/fetch_cmd carry that request's address and command.
- R3: In every cycle with req_valid high, exactly one of req_hit and req_retry is 1. With req_valid low, both are 0.
- R4: Between recording a request and the first cycle after cpl_ready is sampled high, every request is retried, including one equal to the recorded request.
- R5: Once the completion is ready, a request equal to the recorded one in both address and command gets req_hit. The slot is then empty, so the next different request is recorded (fetch_go follows).
- R6: While the completion is ready, a request that differs in address only, or in command only, is retried and is not recorded (no fetch_go follows).
- R7: The completion can be claimed in each of the EXPIRE_CYCLES cycles that follow the cycle in which cpl_ready is sampled. A matching request in the last of them still gets req_hit.
- R8: If the completion is not claimed, discard is 1 for exactly one cycle: the cycle EXPIRE_CYCLES+1 after the one in which cpl_ready is sampled. In that cycle a request is retried, not recorded and not hit.
- R9: After a discard the slot is empty. A different request is recorded, fetched, and then gets req_hit when it returns after its own completion.
- R10: A cpl_ready pulse that arrives while no request is recorded has no effect. A request recorded afterwards is still retried on a matching re-request until its own cpl_ready arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Requester-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read request is presented this cycle |
| req_addr | input | ADDR_W | Address of the presented request |
| req_cmd | input | CMD_W | Bus command of the presented request |
| cpl_ready | input | 1 | Downstream completion for the recorded request is ready |
| req_hit | output | 1 | Presented request claims the ready completion |
| req_retry | output | 1 | Presented request must be retried |
| discard | output | 1 | One-cycle pulse: unclaimed completion flushed |
| fetch_go | output | 1 | One-cycle pulse: start downstream access |
| fetch_addr | output | ADDR_W | Recorded request address |
| fetch_cmd | output | CMD_W | Recorded request command |

## Verification
The bench goes after the edges of the claim window. A claim in the last allowed cycle must still hit, and a request in the discard cycle must be neither hit nor recorded. A timer that is off by one would drop the late claim or hand out stale data. A matching re-request made before the completion is ready must get a retry; a tracker that compared too early would hand out data that does not exist yet. Requests that differ only in command, or only in address, must be refused, which exposes a comparator that checks just one field. A stray completion pulse with no request recorded must not arm the slot.

// File: rtl/rd_defer_pkg.sv
package rd_defer_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_READY = 2'd2
  } slot_state_t;
endpackage

// File: rtl/rd_defer_slot.sv
module rd_defer_slot #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CMD_W-1:0]  in_cmd,
  output logic [ADDR_W-1:0] held_addr,
  output logic [CMD_W-1:0]  held_cmd,
  output logic              same_req
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;

  always_comb begin
    addr_d = addr_q;
    cmd_d  = cmd_q;
    if (load_en) begin
      addr_d = in_addr;
      cmd_d  = in_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cmd_q  <= cmd_d;
    end
  end

  assign held_addr = addr_q;
  assign held_cmd  = cmd_q;
  assign same_req  = (in_addr == addr_q) && (in_cmd == cmd_q);
endmodule

// File: rtl/rd_defer_timer.sv
module rd_defer_timer #(
  parameter int EXPIRE_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(EXPIRE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EXPIRE_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LIMIT);
endmodule

// File: rtl/rd_defer_tracker.sv
module rd_defer_tracker #(
  parameter int ADDR_W        = 32,
  parameter int CMD_W         = 4,
  parameter int EXPIRE_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              cpl_ready,
  output logic              req_hit,
  output logic              req_retry,
  output logic              discard,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [CMD_W-1:0]  fetch_cmd
);
  import rd_defer_pkg::*;

  slot_state_t st_q, st_d;
  logic        load_en, same_req, expired, go_q;

  rd_defer_slot #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .in_addr(req_addr), .in_cmd(req_cmd),
    .held_addr(fetch_addr), .held_cmd(fetch_cmd), .same_req(same_req)
  );

  rd_defer_timer #(.EXPIRE_CYCLES(EXPIRE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == SLOT_READY), .expired(expired)
  );

  always_comb begin
    st_d      = st_q;
    load_en   = 1'b0;
    req_hit   = 1'b0;
    req_retry = 1'b0;
    discard   = 1'b0;
    unique case (st_q)
      SLOT_EMPTY: begin
        if (req_valid) begin
          req_retry = 1'b1;
          load_en   = 1'b1;
          st_d      = SLOT_FETCH;
        end
      end
      SLOT_FETCH: begin
        req_retry = req_valid;
        if (cpl_ready) st_d = SLOT_READY;
      end
      SLOT_READY: begin
        if (expired) begin
          discard   = 1'b1;
          req_retry = req_valid;
          st_d      = SLOT_EMPTY;
        end else if (req_valid && same_req) begin
          req_hit = 1'b1;
          st_d    = SLOT_EMPTY;
        end else begin
          req_retry = req_valid;
        end
      end
      default: st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SLOT_EMPTY;
      go_q <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= load_en;
    end
  end

  assign fetch_go = go_q;
endmodule

// File: rtl/rd_defer_tracker_chk.sv
module rd_defer_tracker_chk #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CMD_W-1:0]  req_cmd,
  input logic              req_hit,
  input logic              req_retry,
  input logic              discard,
  input logic              fetch_go,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [CMD_W-1:0]  fetch_cmd
);
  assert_one_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_hit != req_retry));
  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_hit && !req_retry));
  assert_hit_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> (req_addr == fetch_addr && req_cmd == fetch_cmd));
  assert_fetch_after_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> $past(req_retry));
  assert_fetch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);
  assert_discard_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);
  assert_discard_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !req_hit);
  assert_no_fetch_after_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !fetch_go);
endmodule

bind rd_defer_tracker rd_defer_tracker_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_cmd(req_cmd), .req_hit(req_hit), .req_retry(req_retry),
  .discard(discard), .fetch_go(fetch_go), .fetch_addr(fetch_addr),
  .fetch_cmd(fetch_cmd)
);

// File: tb/rd_defer_tracker_bench.sv
module rd_defer_tracker_bench;
  localparam int AW  = 32;
  localparam int CW  = 4;
  localparam int EXP = 65536;

  logic clk, rst_n, req_valid, cpl_ready;
  logic [AW-1:0] req_addr, fetch_addr;
  logic [CW-1:0] req_cmd, fetch_cmd;
  logic req_hit, req_retry, discard, fetch_go;

  int total = 0, bad = 0;
  logic s_hit, s_retry, s_disc, s_go;
  logic [AW-1:0] s_faddr;
  logic [CW-1:0] s_fcmd;

  rd_defer_tracker #(.ADDR_W(AW), .CMD_W(CW), .EXPIRE_CYCLES(EXP)) u_rd_defer_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .cpl_ready(cpl_ready), .req_hit(req_hit),
    .req_retry(req_retry), .discard(discard), .fetch_go(fetch_go),
    .fetch_addr(fetch_addr), .fetch_cmd(fetch_cmd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample combinational and registered outputs before posedge
  task automatic cyc(input logic v, input logic [AW-1:0] a, input logic [CW-1:0] c, input logic cpl);
    @(negedge clk);
    req_valid = v; req_addr = a; req_cmd = c; cpl_ready = cpl;
    #1;
    s_hit = req_hit; s_retry = req_retry; s_disc = discard; s_go = fetch_go;
    s_faddr = fetch_addr; s_fcmd = fetch_cmd;
  endtask

  task automatic idle(); cyc(1'b0, '0, '0, 1'b0); endtask

  // record a request and confirm the fetch pulse
  task automatic open_req(input logic [AW-1:0] a, input logic [CW-1:0] c, input string tag);
    cyc(1'b1, a, c, 1'b0);
    check(s_retry && !s_hit, {tag, " R2 retry on record"}, {s_hit, s_retry}, 2'b01);
    idle();
    check(s_go && s_faddr == a && s_fcmd == c, {tag, " R2 fetch"}, s_faddr, a);
  endtask

  task automatic t_reset();
    idle();
    check(!s_hit && !s_retry && !s_disc && !s_go, "R1 reset outputs",
          {s_hit, s_retry, s_disc, s_go}, 0);
    idle();
    check(!s_go, "R1 no fetch while idle", s_go, 0);
  endtask

  task automatic t_basic();
    open_req(32'h1000, 4'h6, "basic");
    idle();
    check(!s_go, "R2 fetch is one cycle", s_go, 0);
    cyc(1'b1, 32'h1000, 4'h6, 1'b0);
    check(s_retry && !s_hit, "R4 match retried before ready", {s_hit, s_retry}, 2'b01);
    cyc(1'b1, 32'h2000, 4'h6, 1'b1);
    check(s_retry && !s_hit, "R4 other retried, R3", {s_hit, s_retry}, 2'b01);
    cyc(1'b1, 32'h1000, 4'h6, 1'b0);
    check(s_hit && !s_retry, "R5 match hits", {s_hit, s_retry}, 2'b10);
    open_req(32'h3000, 4'hA, "R5 slot freed");
    cyc(1'b1, 32'h3000, 4'hA, 1'b1);
    cyc(1'b1, 32'h3000, 4'hA, 1'b0);
    check(s_hit, "R5 second hit", s_hit, 1);
  endtask

  task automatic t_mismatch();
    open_req(32'h4000, 4'h6, "mm");
    cyc(1'b0, '0, '0, 1'b1);
    cyc(1'b1, 32'h4000, 4'h7, 1'b0);
    check(s_retry && !s_hit, "R6 cmd differs retried", {s_hit, s_retry}, 2'b01);
    cyc(1'b1, 32'h4004, 4'h6, 1'b0);
    check(s_retry && !s_hit && !s_go, "R6 addr differs retried, no fetch", {s_hit, s_retry, s_go}, 3'b010);
    idle();
    check(!s_go && s_faddr == 32'h4000, "R6 not recorded", s_faddr, 32'h4000);
    cyc(1'b1, 32'h4000, 4'h6, 1'b0);
    check(s_hit, "R6 original still hits", s_hit, 1);
  endtask

  task automatic t_stray();
    cyc(1'b0, '0, '0, 1'b1);
    open_req(32'h5000, 4'h6, "R10");
    cyc(1'b1, 32'h5000, 4'h6, 1'b0);
    check(s_retry && !s_hit, "R10 stray ready ignored", {s_hit, s_retry}, 2'b01);
    cyc(1'b0, '0, '0, 1'b1);
    cyc(1'b1, 32'h5000, 4'h6, 1'b0);
    check(s_hit, "R10 hit after own ready", s_hit, 1);
  endtask

  task automatic t_late_claim();
    int seen;
    open_req(32'h6000, 4'h6, "R7");
    cyc(1'b0, '0, '0, 1'b1);
    seen = 0;
    for (int j = 0; j < EXP - 1; j++) begin
      idle();
      if (s_disc) seen++;
    end
    check(seen == 0, "R7 no early discard", seen, 0);
    cyc(1'b1, 32'h6000, 4'h6, 1'b0);
    check(s_hit && !s_disc, "R7 claim in last cycle", {s_hit, s_disc}, 2'b10);
  endtask

  task automatic t_expiry();
    int seen;
    open_req(32'h7000, 4'h6, "R8");
    cyc(1'b0, '0, '0, 1'b1);
    seen = 0;
    for (int j = 0; j < EXP; j++) begin
      idle();
      if (s_disc) seen++;
    end
    check(seen == 0, "R8 no discard inside window", seen, 0);
    cyc(1'b1, 32'h7000, 4'h6, 1'b0);
    check(s_disc && s_retry && !s_hit, "R8 discard cycle", {s_disc, s_retry, s_hit}, 3'b110);
    cyc(1'b1, 32'h8000, 4'h2, 1'b0);
    check(!s_disc && !s_go && s_retry, "R8 pulse ends, not recorded, R9 recorded now",
          {s_disc, s_go, s_retry}, 3'b001);
    idle();
    check(s_go && s_faddr == 32'h8000 && s_fcmd == 4'h2, "R9 new fetch", s_faddr, 32'h8000);
    cyc(1'b0, '0, '0, 1'b1);
    cyc(1'b1, 32'h8000, 4'h2, 1'b0);
    check(s_hit, "R9 new request completes", s_hit, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0; cpl_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mismatch();
    t_stray();
    t_late_claim();
    t_expiry();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule